// File: doc/BRIEF.md
# Hashed Page Table Walker

The walker resolves one translation request into a page table entry held in an external memory. From a virtual segment identifier and a page index it computes a hash that selects an eight-entry group in a table whose base address and size mask are inputs. It reads the entries one at a time through a 32-bit request/acknowledge memory port and checks each one for a valid, matching tag. A matching entry's rights are decoded from an access key and its two protection bits. If the first group does not grant the access, the walker repeats the search in a second group addressed by the complemented hash.

When an entry is selected, the walker maintains its referenced and changed flags and writes the second word back only when a flag actually changes. The caller receives a one-cycle done pulse with a status code, the real page number and a read/write/execute permission vector. Segment lookup and caching of results are left to the surrounding logic.

Top module: `hpt_walker`

## Requirements
- R1: The first group's byte offset is ((vsid XOR page_index) × 64) AND tbl_mask. Slot s of a group sits at offset + 8·s. The walker reads its tag word at +0 and then its flag word at +4, slots in ascending order, each address added to tbl_base.
- R2: The second group uses the bitwise complement of the first hash. It is searched only when the first group did not grant the access.
- R3: An entry qualifies only if tag-word bit 31 (valid) is 1, bit 6 (group select) equals 0 in the first group and 1 in the second, bits [30:7] equal vsid, and bits [5:0] equal page_index[15:10].
- R4: Rights come from flag-word bits [1:0] (pp). With key 0: pp 0, 1 and 2 give read and write, and pp 3 gives read only. With key 1: pp 0 gives nothing, pp 1 and 3 give read, and pp 2 gives read and write. Execute is given whenever req_nx is 0. Access codes are 0 read, 1 write and 2 execute.
- R5: The first qualifying entry that grants the access ends the group search. A qualifying entry that denies it is remembered, and the search goes on.
- R6: A qualifying entry whose flag word, under mask 0xFFFFF07B, differs from an earlier match in the same request ends that group's search as a miss. This aborted search updates no flags.
- R7: A second-group result replaces the first-group result unless the second group found no match or was aborted.
- R8: On a selected entry, the walker sets flag-word bit 8 (referenced) if it is clear. It sets bit 7 (changed) only on a granted write. Otherwise, while bit 7 is clear, write permission is removed from the reported vector. The flag word is written back only if it changed.
- R9: done pulses for one cycle. status is 0 granted, 1 protection fault, 2 miss. rpn is flag-word bits [31:12], and perm is {exec, write, read}. A miss reports rpn 0 and perm 0.
- R10: busy is high from acceptance until done. req_valid is ignored while busy. A memory request holds its address and direction until mem_ack.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Start a walk (accepted when not busy) |
| req_vsid | input | 24 | Virtual segment identifier |
| req_pidx | input | 16 | Page index (address bits 27:12) |
| req_key | input | 1 | Access key selecting the protection decode |
| req_nx | input | 1 | No-execute segment |
| req_acc | input | 2 | Access type: 0 read, 1 write, 2 execute |
| tbl_base | input | 32 | Table base byte address |
| tbl_mask | input | 32 | Mask applied to the group offset |
| busy | output | 1 | Walk in progress |
| done | output | 1 | One-cycle completion pulse |
| status | output | 2 | 0 granted, 1 protection, 2 miss |
| rpn | output | 20 | Real page number of the selected entry |
| perm | output | 3 | {exec, write, read} rights |
| mem_req | output | 1 | Memory request, held until mem_ack |
| mem_we | output | 1 | 1 for a write |
| mem_addr | output | 32 | Byte address |
| mem_wdata | output | 32 | Write data |
| mem_ack | input | 1 | Request completed |
| mem_rdata | input | 32 | Read data, valid with mem_ack |

## Verification
On every cycle, the assertions check several properties. Memory requests stay stable until acknowledged, and writes only ever target a flag word of an entry that was found. done lasts one cycle, and a granted result always carries the right for the requested access. A miss carries empty fields, and the second group is never entered after a grant. Only the bench's scenarios can show which entry is chosen and when the search stops. They also show that a conflicting later match becomes a miss, that a second-group result replaces or keeps the first, and the exact flag values written back. They check the read address sequence, the protection decode across all key, pp and access combinations, and that a request issued while busy is dropped.

// File: rtl/hpt_pkg.sv
package hpt_pkg;

  localparam logic [1:0] STAT_GRANT = 2'd0;
  localparam logic [1:0] STAT_PROT  = 2'd1;
  localparam logic [1:0] STAT_MISS  = 2'd2;

  localparam logic [1:0] ACC_READ  = 2'd0;
  localparam logic [1:0] ACC_WRITE = 2'd1;
  localparam logic [1:0] ACC_EXEC  = 2'd2;

  localparam int TAG_VALID_BIT = 31;
  localparam int TAG_HSEL_BIT  = 6;
  localparam int FLG_REF_BIT   = 8;
  localparam int FLG_CHG_BIT   = 7;

  // page number, cache attributes and protection must agree between matches
  localparam logic [31:0] AGREE_MASK = 32'hFFFF_F07B;

  // rights vector is {exec, write, read}
  function automatic logic [2:0] pp_rights(input logic key, input logic [1:0] pp,
                                           input logic nx);
    logic rd, wr;
    if (!key) begin
      rd = 1'b1;
      wr = (pp != 2'd3);
    end else begin
      rd = (pp != 2'd0);
      wr = (pp == 2'd2);
    end
    return {~nx, wr, rd};
  endfunction

  function automatic logic access_ok(input logic [2:0] rights, input logic [1:0] acc);
    case (acc)
      ACC_EXEC:  return rights[2];
      ACC_WRITE: return rights[1];
      default:   return rights[0];
    endcase
  endfunction

endpackage

// File: rtl/hpt_addr_gen.sv
module hpt_addr_gen #(
  parameter int VSID_W = 24,
  parameter int PIDX_W = 16,
  parameter int SLOTS  = 8,
  parameter int SLOT_W = $clog2(SLOTS)
) (
  input  logic [31:0]       base,
  input  logic [31:0]       mask,
  input  logic [VSID_W-1:0] vsid,
  input  logic [PIDX_W-1:0] pidx,
  input  logic              second,
  input  logic [SLOT_W-1:0] slot,
  input  logic              flag_word,
  output logic [31:0]       addr
);
  localparam int GRP_SHIFT = $clog2(SLOTS * 8);

  logic [31:0] hash;
  logic [31:0] grp_off;
  logic [31:0] slot_off;

  always_comb begin
    hash = 32'(vsid) ^ 32'(pidx);
    if (second) hash = ~hash;
    grp_off  = (hash << GRP_SHIFT) & mask;
    slot_off = 32'({slot, 3'b000});
    addr     = base + grp_off + slot_off + (flag_word ? 32'd4 : 32'd0);
  end
endmodule

// File: rtl/hpt_entry_eval.sv
module hpt_entry_eval #(
  parameter int VSID_W = 24
) (
  input  logic [31:0]       tag_w,
  input  logic [31:0]       flg_w,
  input  logic              second,
  input  logic [VSID_W-1:0] vsid,
  input  logic [5:0]        api,
  input  logic              key,
  input  logic              nx,
  input  logic [1:0]        acc,
  input  logic              have_match,
  input  logic [31:0]       prev_flg,
  output logic              qual,
  output logic              clash,
  output logic [2:0]        rights,
  output logic              grant
);
  import hpt_pkg::*;

  logic tag_hit;

  always_comb begin
    tag_hit = (tag_w[7 +: VSID_W] == vsid) && (tag_w[5:0] == api);
    qual    = tag_w[TAG_VALID_BIT] && (tag_w[TAG_HSEL_BIT] == second) && tag_hit;
    clash   = have_match && ((prev_flg & AGREE_MASK) != (flg_w & AGREE_MASK));
    rights  = pp_rights(key, flg_w[1:0], nx);
    grant   = access_ok(rights, acc);
  end
endmodule

// File: rtl/hpt_flag_upd.sv
module hpt_flag_upd (
  input  logic [31:0] sel_flg,
  input  logic        sel_grant,
  input  logic [1:0]  acc,
  output logic [31:0] new_flg,
  output logic        store,
  output logic        keep_wr
);
  import hpt_pkg::*;

  logic is_wr;
  logic chg_set;

  always_comb begin
    is_wr   = (acc == ACC_WRITE);
    chg_set = sel_grant && is_wr;
    new_flg = sel_flg;
    new_flg[FLG_REF_BIT] = 1'b1;
    if (chg_set) new_flg[FLG_CHG_BIT] = 1'b1;
    store   = (new_flg != sel_flg);
    keep_wr = sel_flg[FLG_CHG_BIT] || chg_set;
  end
endmodule

// File: rtl/hpt_walker.sv
module hpt_walker #(
  parameter int VSID_W = 24,
  parameter int PIDX_W = 16,
  parameter int SLOTS  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [VSID_W-1:0] req_vsid,
  input  logic [PIDX_W-1:0] req_pidx,
  input  logic              req_key,
  input  logic              req_nx,
  input  logic [1:0]        req_acc,
  input  logic [31:0]       tbl_base,
  input  logic [31:0]       tbl_mask,
  output logic              busy,
  output logic              done,
  output logic [1:0]        status,
  output logic [19:0]       rpn,
  output logic [2:0]        perm,
  output logic              mem_req,
  output logic              mem_we,
  output logic [31:0]       mem_addr,
  output logic [31:0]       mem_wdata,
  input  logic              mem_ack,
  input  logic [31:0]       mem_rdata
);
  import hpt_pkg::*;

  localparam int SLOT_W = $clog2(SLOTS);
  localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(SLOTS - 1);

  typedef enum logic [2:0] {
    S_IDLE, S_RD_TAG, S_RD_FLG, S_EVAL, S_FLAGS, S_WB, S_PASS_END, S_FIN
  } walk_state_e;

  walk_state_e state_q;

  logic [VSID_W-1:0] vsid_q;
  logic [PIDX_W-1:0] pidx_q;
  logic              key_q, nx_q;
  logic [1:0]        acc_q;
  logic              second_q;
  logic [SLOT_W-1:0] slot_q, good_q;
  logic [31:0]       tag_q, flg_q;
  logic              have_match_q, found_q;
  logic [31:0]       sel_flg_q;
  logic [2:0]        sel_rights_q;
  logic              sel_grant_q;
  logic [1:0]        status_q;
  logic [19:0]       rpn_q;
  logic [2:0]        perm_q;

  // named internal events
  logic        ev_qual, ev_clash, ev_grant;
  logic [2:0]  ev_rights;
  logic [31:0] fl_new;
  logic        fl_store, fl_keep_wr;
  logic [1:0]  pass_stat;
  logic [19:0] pass_rpn;
  logic [2:0]  pass_perm;
  logic        accept;

  hpt_addr_gen #(.VSID_W(VSID_W), .PIDX_W(PIDX_W), .SLOTS(SLOTS)) u_addr (
    .base     (tbl_base),
    .mask     (tbl_mask),
    .vsid     (vsid_q),
    .pidx     (pidx_q),
    .second   (second_q),
    .slot     ((state_q == S_WB) ? good_q : slot_q),
    .flag_word(state_q != S_RD_TAG),
    .addr     (mem_addr)
  );

  hpt_entry_eval #(.VSID_W(VSID_W)) u_eval (
    .tag_w     (tag_q),
    .flg_w     (flg_q),
    .second    (second_q),
    .vsid      (vsid_q),
    .api       (pidx_q[PIDX_W-1 -: 6]),
    .key       (key_q),
    .nx        (nx_q),
    .acc       (acc_q),
    .have_match(have_match_q),
    .prev_flg  (sel_flg_q),
    .qual      (ev_qual),
    .clash     (ev_clash),
    .rights    (ev_rights),
    .grant     (ev_grant)
  );

  hpt_flag_upd u_flags (
    .sel_flg  (sel_flg_q),
    .sel_grant(sel_grant_q),
    .acc      (acc_q),
    .new_flg  (fl_new),
    .store    (fl_store),
    .keep_wr  (fl_keep_wr)
  );

  always_comb begin
    if (found_q) begin
      pass_stat = sel_grant_q ? STAT_GRANT : STAT_PROT;
      pass_rpn  = sel_flg_q[31:12];
      pass_perm = sel_rights_q & {1'b1, fl_keep_wr, 1'b1};
    end else begin
      pass_stat = STAT_MISS;
      pass_rpn  = '0;
      pass_perm = '0;
    end
  end

  assign accept    = (state_q == S_IDLE) && req_valid;
  assign busy      = (state_q != S_IDLE);
  assign done      = (state_q == S_FIN);
  assign status    = status_q;
  assign rpn       = rpn_q;
  assign perm      = perm_q;
  assign mem_req   = (state_q == S_RD_TAG) || (state_q == S_RD_FLG) || (state_q == S_WB);
  assign mem_we    = (state_q == S_WB);
  assign mem_wdata = fl_new;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q      <= S_IDLE;
      vsid_q       <= '0;
      pidx_q       <= '0;
      key_q        <= 1'b0;
      nx_q         <= 1'b0;
      acc_q        <= ACC_READ;
      second_q     <= 1'b0;
      slot_q       <= '0;
      good_q       <= '0;
      tag_q        <= '0;
      flg_q        <= '0;
      have_match_q <= 1'b0;
      found_q      <= 1'b0;
      sel_flg_q    <= '0;
      sel_rights_q <= '0;
      sel_grant_q  <= 1'b0;
      status_q     <= STAT_MISS;
      rpn_q        <= '0;
      perm_q       <= '0;
    end else begin
      case (state_q)
        S_IDLE: if (accept) begin
          vsid_q       <= req_vsid;
          pidx_q       <= req_pidx;
          key_q        <= req_key;
          nx_q         <= req_nx;
          acc_q        <= req_acc;
          second_q     <= 1'b0;
          slot_q       <= '0;
          have_match_q <= 1'b0;
          found_q      <= 1'b0;
          state_q      <= S_RD_TAG;
        end
        S_RD_TAG: if (mem_ack) begin
          tag_q   <= mem_rdata;
          state_q <= S_RD_FLG;
        end
        S_RD_FLG: if (mem_ack) begin
          flg_q   <= mem_rdata;
          state_q <= S_EVAL;
        end
        S_EVAL: begin
          if (ev_qual && ev_clash) begin
            found_q <= 1'b0;
            state_q <= S_PASS_END;
          end else begin
            if (ev_qual) begin
              have_match_q <= 1'b1;
              found_q      <= 1'b1;
              good_q       <= slot_q;
              sel_flg_q    <= flg_q;
              sel_rights_q <= ev_rights;
              sel_grant_q  <= ev_grant;
            end
            if (ev_qual && ev_grant) begin
              state_q <= S_FLAGS;
            end else if (slot_q == LAST_SLOT) begin
              state_q <= (found_q || ev_qual) ? S_FLAGS : S_PASS_END;
            end else begin
              slot_q  <= slot_q + 1'b1;
              state_q <= S_RD_TAG;
            end
          end
        end
        S_FLAGS: state_q <= fl_store ? S_WB : S_PASS_END;
        S_WB: if (mem_ack) state_q <= S_PASS_END;
        S_PASS_END: begin
          if (!second_q) begin
            status_q <= pass_stat;
            rpn_q    <= pass_rpn;
            perm_q   <= pass_perm;
            if (pass_stat == STAT_GRANT) begin
              state_q <= S_FIN;
            end else begin
              second_q <= 1'b1;
              slot_q   <= '0;
              found_q  <= 1'b0;
              state_q  <= S_RD_TAG;
            end
          end else begin
            if (found_q) begin
              status_q <= pass_stat;
              rpn_q    <= pass_rpn;
              perm_q   <= pass_perm;
            end
            state_q <= S_FIN;
          end
        end
        S_FIN:   state_q <= S_IDLE;
        default: state_q <= S_IDLE;
      endcase
    end
  end

  // R10
  mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we));

  // R8
  wb_flag_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_we |-> mem_addr[2] && found_q);

  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R9
  miss_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done && (status == STAT_MISS) |-> (perm == 3'd0) && (rpn == 20'd0));

  // R4
  grant_right_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done && (status == STAT_GRANT) |-> access_ok(perm, acc_q));

  // R2
  second_after_fail_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(second_q) |-> (status_q != STAT_GRANT));

  // R10
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !done |=> busy);

endmodule

// File: tb/tb_hpt_walker.sv
module tb_hpt_walker;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] MASK = 32'h0000_01C0;
  localparam logic [23:0] VS   = 24'h000005;
  localparam logic [15:0] PI   = 16'h0003;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [23:0] req_vsid = '0;
  logic [15:0] req_pidx = '0;
  logic        req_key = 1'b0, req_nx = 1'b0;
  logic [1:0]  req_acc = 2'd0;
  logic [31:0] tbl_base = '0;
  logic [31:0] tbl_mask = MASK;
  logic        busy, done;
  logic [1:0]  status;
  logic [19:0] rpn;
  logic [2:0]  perm;
  logic        mem_req, mem_we;
  logic [31:0] mem_addr, mem_wdata;
  logic        mem_ack = 1'b0;
  logic [31:0] mem_rdata = '0;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  hpt_walker dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_vsid(req_vsid),
    .req_pidx(req_pidx), .req_key(req_key), .req_nx(req_nx), .req_acc(req_acc),
    .tbl_base(tbl_base), .tbl_mask(tbl_mask), .busy(busy), .done(done),
    .status(status), .rpn(rpn), .perm(perm), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata)
  );

  // memory model with setup port
  logic [31:0] mem [128];
  logic [31:0] rd_log [64];
  int          rd_cnt = 0, wr_cnt = 0;
  logic        tb_clr = 1'b0, tb_wr = 1'b0;
  logic [6:0]  tb_idx = '0;
  logic [31:0] tb_dat = '0;
  logic [31:0] rel_addr;
  assign rel_addr = mem_addr - tbl_base;

  always @(posedge clk) begin
    if (tb_clr) begin
      for (int k = 0; k < 128; k++) mem[k] <= '0;
      rd_cnt  <= 0;
      wr_cnt  <= 0;
      mem_ack <= 1'b0;
    end else if (tb_wr) begin
      mem[tb_idx] <= tb_dat;
    end else if (mem_req && !mem_ack) begin
      mem_ack <= 1'b1;
      if (mem_we) begin
        mem[rel_addr[8:2]] <= mem_wdata;
        wr_cnt <= wr_cnt + 1;
      end else begin
        mem_rdata <= mem[rel_addr[8:2]];
        if (rd_cnt < 64) rd_log[rd_cnt[5:0]] <= mem_addr;
        rd_cnt <= rd_cnt + 1;
      end
    end else begin
      mem_ack <= 1'b0;
    end
  end

  // independent restatement of group placement
  function automatic logic [31:0] group_off(input logic [23:0] v, input logic [15:0] p,
                                            input logic sec);
    logic [31:0] h;
    h = {8'h00, v} ^ {16'h0000, p};
    if (sec) h = ~h;
    return (h * 32'd64) & MASK;
  endfunction

  function automatic logic [6:0] word_idx(input logic sec, input int slot, input int wd);
    logic [31:0] o;
    o = group_off(VS, PI, sec) + 32'(slot * 8 + wd * 4);
    return o[8:2];
  endfunction

  function automatic logic [31:0] tag_word(input logic [23:0] v, input logic [5:0] api,
                                           input logic h);
    return {1'b1, v, h, api};
  endfunction

  function automatic logic [31:0] flag_word(input logic [19:0] pg, input logic [1:0] rc,
                                            input logic [1:0] pp);
    return {pg, 3'b000, rc, 5'b00000, pp};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic clear_mem();
    @(negedge clk); tb_clr = 1'b1;
    @(negedge clk); tb_clr = 1'b0;
  endtask

  task automatic poke(input logic [6:0] idx, input logic [31:0] dat);
    @(negedge clk); tb_idx = idx; tb_dat = dat; tb_wr = 1'b1;
    @(negedge clk); tb_wr = 1'b0;
  endtask

  task automatic put_entry(input logic sec, input int slot, input logic [31:0] t,
                           input logic [31:0] f);
    poke(word_idx(sec, slot, 0), t);
    poke(word_idx(sec, slot, 1), f);
  endtask

  task automatic start_walk(input logic key, input logic [1:0] acc, input logic nx);
    @(negedge clk);
    req_vsid = VS; req_pidx = PI; req_key = key; req_acc = acc; req_nx = nx;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic wait_done(input string req);
    bit seen = 1'b0;
    for (int n = 0; n < 3000; n++) begin
      if (done) begin seen = 1'b1; break; end
      @(negedge clk);
    end
    check(req, {31'd0, seen}, 32'd1);
  endtask

  // {key, pp, acc, nx, rc, exp_status, exp_perm, exp_rc, exp_write}
  localparam logic [15:0] VEC [10] = '{
    {1'b0, 2'd0, 2'd0, 1'b0, 2'b00, 2'd0, 3'd5, 2'b10, 1'b1},
    {1'b0, 2'd2, 2'd1, 1'b0, 2'b00, 2'd0, 3'd7, 2'b11, 1'b1},
    {1'b0, 2'd3, 2'd1, 1'b0, 2'b11, 2'd1, 3'd5, 2'b11, 1'b0},
    {1'b1, 2'd0, 2'd0, 1'b1, 2'b10, 2'd1, 3'd0, 2'b10, 1'b0},
    {1'b1, 2'd1, 2'd0, 1'b0, 2'b11, 2'd0, 3'd5, 2'b11, 1'b0},
    {1'b1, 2'd2, 2'd1, 1'b1, 2'b10, 2'd0, 3'd3, 2'b11, 1'b1},
    {1'b1, 2'd3, 2'd1, 1'b0, 2'b00, 2'd1, 3'd5, 2'b10, 1'b1},
    {1'b0, 2'd1, 2'd2, 1'b1, 2'b11, 2'd1, 3'd3, 2'b11, 1'b0},
    {1'b0, 2'd1, 2'd2, 1'b0, 2'b01, 2'd0, 3'd7, 2'b11, 1'b1},
    {1'b0, 2'd2, 2'd0, 1'b0, 2'b10, 2'd0, 3'd5, 2'b10, 1'b0}
  };

  localparam logic [19:0] PG_A = 20'h12345;
  localparam logic [19:0] PG_B = 20'h2BEEF;

  initial begin
    // reset state
    repeat (3) @(negedge clk);
    check("R10 reset busy", {31'd0, busy}, 32'd0);
    check("R9 reset done", {31'd0, done}, 32'd0);
    check("R10 reset mem_req", {31'd0, mem_req}, 32'd0);
    rst_n = 1'b1;

    // protection decode and flag maintenance, single entry in slot 0
    for (int v = 0; v < 10; v++) begin
      logic [15:0] e;
      e = VEC[v];
      tbl_base = 32'h0;
      clear_mem();
      put_entry(1'b0, 0, tag_word(VS, PI[15:10], 1'b0), flag_word(PG_A, e[9:8], e[14:13]));
      start_walk(e[15], e[12:11], e[10]);
      wait_done("R9 vec done");
      check($sformatf("R4 vec %0d status", v), {30'd0, status}, {30'd0, e[7:6]});
      check($sformatf("R4 vec %0d perm", v), {29'd0, perm}, {29'd0, e[5:3]});
      check($sformatf("R9 vec %0d rpn", v), {12'd0, rpn}, {12'd0, PG_A});
      check($sformatf("R8 vec %0d flag word", v), mem[word_idx(1'b0, 0, 1)],
            flag_word(PG_A, e[2:1], e[14:13]));
      check($sformatf("R8 vec %0d writes", v), 32'(wr_cnt), {31'd0, e[0]});
    end

    // empty table: address sequence, secondary group, miss encoding
    tbl_base = 32'h0000_1000;
    clear_mem();
    start_walk(1'b0, 2'd0, 1'b0);
    wait_done("R9 empty done");
    check("R9 empty status", {30'd0, status}, 32'd2);
    check("R9 empty perm", {29'd0, perm}, 32'd0);
    check("R1 first tag read", rd_log[0], 32'h1000 + group_off(VS, PI, 1'b0));
    check("R1 first flag read", rd_log[1], 32'h1004 + group_off(VS, PI, 1'b0));
    check("R1 second slot read", rd_log[2], 32'h1008 + group_off(VS, PI, 1'b0));
    check("R2 secondary first read", rd_log[16], 32'h1000 + group_off(VS, PI, 1'b1));
    check("R2 total reads", 32'(rd_cnt), 32'd32);

    // non-qualifying entries
    tbl_base = 32'h0;
    clear_mem();
    put_entry(1'b0, 2, tag_word(VS, PI[15:10], 1'b1), flag_word(PG_A, 2'b11, 2'd2));
    put_entry(1'b0, 3, tag_word(VS, PI[15:10], 1'b0) & 32'h7FFF_FFFF, flag_word(PG_A, 2'b11, 2'd2));
    put_entry(1'b0, 4, tag_word(24'h000006, PI[15:10], 1'b0), flag_word(PG_A, 2'b11, 2'd2));
    put_entry(1'b0, 5, tag_word(VS, 6'h01, 1'b0), flag_word(PG_A, 2'b11, 2'd2));
    put_entry(1'b1, 1, tag_word(VS, PI[15:10], 1'b0), flag_word(PG_A, 2'b11, 2'd2));
    start_walk(1'b0, 2'd0, 1'b0);
    wait_done("R3 done");
    check("R3 no qualifying entry", {30'd0, status}, 32'd2);
    check("R3 no write-back", 32'(wr_cnt), 32'd0);

    // secondary group hit
    clear_mem();
    put_entry(1'b1, 5, tag_word(VS, PI[15:10], 1'b1), flag_word(PG_B, 2'b11, 2'd2));
    start_walk(1'b0, 2'd1, 1'b0);
    wait_done("R2 done");
    check("R2 secondary grant", {30'd0, status}, 32'd0);
    check("R7 secondary rpn", {12'd0, rpn}, {12'd0, PG_B});
    check("R7 secondary perm", {29'd0, perm}, 32'd7);
    check("R2 reads up to slot 5", 32'(rd_cnt), 32'd28);

    // first grant ends the search; a later conflicting entry is never read
    clear_mem();
    put_entry(1'b0, 1, tag_word(VS, PI[15:10], 1'b0), flag_word(PG_A, 2'b11, 2'd3));
    put_entry(1'b0, 4, tag_word(VS, PI[15:10], 1'b0), flag_word(PG_B, 2'b11, 2'd3));
    start_walk(1'b0, 2'd0, 1'b0);
    wait_done("R5 done");
    check("R5 first grant status", {30'd0, status}, 32'd0);
    check("R5 first grant rpn", {12'd0, rpn}, {12'd0, PG_A});
    check("R5 stops after slot 1", 32'(rd_cnt), 32'd4);

    // denied match keeps scanning and hits a conflicting entry
    clear_mem();
    put_entry(1'b0, 0, tag_word(VS, PI[15:10], 1'b0), flag_word(PG_A, 2'b11, 2'd0));
    put_entry(1'b0, 3, tag_word(VS, PI[15:10], 1'b0), flag_word(PG_B, 2'b11, 2'd0));
    start_walk(1'b1, 2'd0, 1'b0);
    wait_done("R6 done");
    check("R6 conflict gives miss", {30'd0, status}, 32'd2);
    check("R5 scan continued past denial", 32'(rd_cnt), 32'd24);

    // primary denial kept when secondary aborts on a conflict
    clear_mem();
    put_entry(1'b0, 0, tag_word(VS, PI[15:10], 1'b0), flag_word(PG_A, 2'b11, 2'd0));
    put_entry(1'b1, 2, tag_word(VS, PI[15:10], 1'b1), flag_word(PG_B, 2'b11, 2'd0));
    start_walk(1'b1, 2'd0, 1'b0);
    wait_done("R7 done");
    check("R7 primary result kept", {30'd0, status}, 32'd1);
    check("R7 primary rpn kept", {12'd0, rpn}, {12'd0, PG_A});
    check("R6 aborted search writes nothing", 32'(wr_cnt), 32'd0);

    // request while busy is ignored
    clear_mem();
    put_entry(1'b0, 6, tag_word(VS, PI[15:10], 1'b0), flag_word(PG_A, 2'b11, 2'd2));
    start_walk(1'b0, 2'd1, 1'b0);
    repeat (3) @(negedge clk);
    check("R10 busy during walk", {31'd0, busy}, 32'd1);
    req_vsid = 24'h000077; req_acc = 2'd0; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    wait_done("R10 done");
    check("R10 original request status", {30'd0, status}, 32'd0);
    check("R10 original request rpn", {12'd0, rpn}, {12'd0, PG_A});
    @(negedge clk);
    check("R10 idle after done", {31'd0, busy}, 32'd0);
    check("R9 done one cycle", {31'd0, done}, 32'd0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL R10 watchdog expired actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule